// File: doc/BRIEF.md
# DDR Command Traffic Monitor

This block watches the command strobes that a DDR controller sends to its PHY on up to four channels. Each channel has four 32-bit counters: write commands, read commands, controller clock cycles and total accesses. They count only while the channel's enable is set. Software reads them over a simple zero-wait-state register bus and takes differences modulo 2^32. Reads never clear a counter, so several readers can difference the same counters independently.

Each channel has one control register. A write to it is masked bit by bit: the upper half of the write data chooses which bits of the lower half take effect. This lets one field, such as the memory-type select, change without a read-modify-write of the enables.

Each channel's register group repeats at a parameterised address stride. A build option lets the control register of channel 0 govern every channel.

Top module: `ddr_traffic_monitor`

## Requirements
- R1: After reset every control register reads 0 and every counter reads 0.
- R2: A bus write to a control register changes only the bits whose mask bit is 1. Bit n of the lower half is masked by bit n+16 of the write data. Stored bits are 0 (timer-count enable), 1 (software enable), 2 (LPDDR2/3 select), 3 (hardware enable), 4 (LPDDR4 select) and 5 (DDR4 select). Bits 15:6 always read as 0.
- R3: The three type-select bits (2, 4, 5) can be rewritten through the mask while bits 0, 1 and 3 keep their values.
- R4: A channel's counters advance only while bit 1 or bit 3 of its governing control register is 1. Bit 0 on its own enables nothing, and with neither enable set all four counters hold.
- R5: While counting is enabled, the cycle counter increments by one on every clock.
- R6: While counting is enabled, the read counter increments by one in each cycle that the channel's read strobe is high. The write counter does the same for the write strobe.
- R7: While counting is enabled, the access counter increments by one in each cycle in which the read strobe, the write strobe or both are high. A cycle with both strobes high counts once.
- R8: Channel c occupies base c*STRIDE, with these offsets: control at 0x04, write count at 0x20, read count at 0x24, cycle count at 0x28 and access count at 0x2C. Strobes of one channel never move the counters of another.
- R9: Counters are 32 bits, free-running and wrap modulo 2^32. A read does not clear a counter, and a bus write to a counter offset changes nothing.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.
- R11: With SHARED_CTRL set, channel 0's control register governs every channel. Writes to the control offsets of the other channels are ignored, and reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase; a write commits when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data: mask in bits 31:16, value in bits 15:0 |
| prdata | output | 32 | Read data, valid in the same cycle while psel is high and pwrite is low |
| rdStrobe | input | NUM_CH | Per-channel read command strobe |
| wrStrobe | input | NUM_CH | Per-channel write command strobe |

## Verification
The bench goes after the write mask in several forms:
- a write with no mask bits set;
- a write whose mask covers only the unstored bits 15:6;
- a write that touches only the type-select bits.

A design that ignored the mask, or that used the wrong half as the mask, would wipe or set the enables. The bench checks that timer-count enable alone keeps every counter frozen, so a design that treated bit 0 as a count enable would be caught. It drives overlapping read and write strobes, which a design that summed the strobes would count twice in the access counter. The bench also checks that reads do not clear counters and that writes to counter offsets are ignored. It confirms that one channel's strobes stay out of its neighbour's counters. In shared-control mode, it shows that a non-zero channel follows channel 0 and that its own control offset ignores writes and reads as zero.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

  localparam int MAX_CH    = 4;
  localparam int CNT_W     = 32;
  localparam int CTRL_BITS = 6;

  // byte offsets inside one channel's group
  localparam int OFF_CTRL = 32'h04;
  localparam int OFF_WR   = 32'h20;
  localparam int OFF_RD   = 32'h24;
  localparam int OFF_CYC  = 32'h28;
  localparam int OFF_ACC  = 32'h2C;

  // control bit positions
  localparam int CB_TIMER = 0;
  localparam int CB_SW    = 1;
  localparam int CB_LP23  = 2;
  localparam int CB_HW    = 3;
  localparam int CB_LP4   = 4;
  localparam int CB_DDR4  = 5;

  typedef enum logic [1:0] {
    K_WR  = 2'd0,
    K_RD  = 2'd1,
    K_CYC = 2'd2,
    K_ACC = 2'd3
  } cnt_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [MAX_CH-1:0] countEn;
    logic              rdCntHit;
    logic [1:0]        rdCh;
    cnt_kind_e         rdKind;
  } dp_cmd_t;

  function automatic int kindOffset(int k);
    case (k)
      0:       return OFF_WR;
      1:       return OFF_RD;
      2:       return OFF_CYC;
      default: return OFF_ACC;
    endcase
  endfunction

endpackage

// File: rtl/ddrmon_ctrl.sv
module ddrmon_ctrl
  import ddrmon_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int STRIDE      = 20,
  parameter int SHARED_CTRL = 0,
  parameter int ADDR_W      = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              psel,
  input  logic                              penable,
  input  logic                              pwrite,
  input  logic [ADDR_W-1:0]                 paddr,
  input  logic [31:0]                       pwdata,
  output logic [31:0]                       ctrlRdata,
  output logic [NUM_CH-1:0][CTRL_BITS-1:0]  ctrlState,
  output dp_cmd_t                           dpCmd
);

  localparam int CH_IDX_W = 2;

  logic                  wrAccess;
  logic                  rdAccess;
  logic [NUM_CH-1:0]     ctrlHit;
  logic                  cntFound;
  logic [CH_IDX_W-1:0]   cntCh;
  cnt_kind_e             cntKind;
  logic [CTRL_BITS-1:0]  wMask;
  logic [CTRL_BITS-1:0]  wVal;
  logic                  unusedPwdata;

  assign wrAccess     = psel & penable & pwrite;
  assign rdAccess     = psel & ~pwrite;
  assign wMask        = pwdata[16 +: CTRL_BITS];
  assign wVal         = pwdata[0 +: CTRL_BITS];
  assign unusedPwdata = ^{pwdata[31:16+CTRL_BITS], pwdata[15:CTRL_BITS]};

  // address decode: lowest channel wins on any overlap
  always_comb begin
    ctrlHit  = '0;
    cntFound = 1'b0;
    cntCh    = '0;
    cntKind  = K_WR;
    for (int c = 0; c < NUM_CH; c++) begin
      if (paddr == ADDR_W'(c * STRIDE + OFF_CTRL)) ctrlHit[c] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (!cntFound && paddr == ADDR_W'(c * STRIDE + kindOffset(k))) begin
          cntFound = 1'b1;
          cntCh    = c[CH_IDX_W-1:0];
          cntKind  = cnt_kind_e'(k[1:0]);
        end
      end
    end
  end

  // control registers, one per channel unless shared
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctrl
    if (SHARED_CTRL == 0 || c == 0) begin : g_own
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ctrlState[c] <= '0;
        end else if (wrAccess && ctrlHit[c]) begin
          ctrlState[c] <= (ctrlState[c] & ~wMask) | (wVal & wMask);
        end
      end
    end else begin : g_none
      assign ctrlState[c] = '0;
    end
  end

  // control readback
  always_comb begin
    ctrlRdata = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (rdAccess && ctrlHit[c]) ctrlRdata = {{(32-CTRL_BITS){1'b0}}, ctrlState[c]};
    end
  end

  // count enables from the governing control register
  always_comb begin
    dpCmd.countEn = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (SHARED_CTRL != 0)
        dpCmd.countEn[c] = ctrlState[0][CB_SW] | ctrlState[0][CB_HW];
      else
        dpCmd.countEn[c] = ctrlState[c][CB_SW] | ctrlState[c][CB_HW];
    end
    dpCmd.rdCntHit = rdAccess & cntFound;
    dpCmd.rdCh     = cntCh;
    dpCmd.rdKind   = cntKind;
  end

endmodule

// File: rtl/ddrmon_datapath.sv
module ddrmon_datapath
  import ddrmon_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  dp_cmd_t                              dpCmd,
  input  logic [NUM_CH-1:0]                    rdStrobe,
  input  logic [NUM_CH-1:0]                    wrStrobe,
  output logic [NUM_CH-1:0][3:0][CNT_W-1:0]    cntArr,
  output logic [31:0]                          cntRdata
);

  logic unusedCmd;
  assign unusedCmd = ^dpCmd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic anyCmd;
    assign anyCmd = rdStrobe[c] | wrStrobe[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cntArr[c] <= '0;
      end else if (dpCmd.countEn[c]) begin
        cntArr[c][K_CYC] <= cntArr[c][K_CYC] + CNT_W'(1);
        if (rdStrobe[c]) cntArr[c][K_RD]  <= cntArr[c][K_RD]  + CNT_W'(1);
        if (wrStrobe[c]) cntArr[c][K_WR]  <= cntArr[c][K_WR]  + CNT_W'(1);
        if (anyCmd)      cntArr[c][K_ACC] <= cntArr[c][K_ACC] + CNT_W'(1);
      end
    end
  end

  always_comb begin
    cntRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (dpCmd.rdCntHit && dpCmd.rdCh == c[1:0]) cntRdata = cntArr[c][dpCmd.rdKind];
    end
  end

endmodule

// File: rtl/ddr_traffic_monitor.sv
module ddr_traffic_monitor
  import ddrmon_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int STRIDE      = 20,
  parameter int SHARED_CTRL = 0,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [NUM_CH-1:0] rdStrobe,
  input  logic [NUM_CH-1:0] wrStrobe
);

  dp_cmd_t                             dpCmd;
  logic [31:0]                         ctrlRdata;
  logic [31:0]                         cntRdata;
  logic [NUM_CH-1:0][CTRL_BITS-1:0]    ctrlState;
  logic [NUM_CH-1:0][3:0][CNT_W-1:0]   cntArr;

  ddrmon_ctrl #(
    .NUM_CH(NUM_CH), .STRIDE(STRIDE), .SHARED_CTRL(SHARED_CTRL), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .ctrlRdata(ctrlRdata),
    .ctrlState(ctrlState), .dpCmd(dpCmd)
  );

  ddrmon_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCmd(dpCmd), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .cntArr(cntArr), .cntRdata(cntRdata)
  );

  assign prdata = ctrlRdata | cntRdata;

endmodule

// File: rtl/ddrmon_checker.sv
module ddrmon_checker
  import ddrmon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int STRIDE = 20,
  parameter int ADDR_W = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               psel,
  input logic                               penable,
  input logic                               pwrite,
  input logic [ADDR_W-1:0]                  paddr,
  input logic [CTRL_BITS-1:0]               maskBits,
  input logic [NUM_CH-1:0]                  rdStrobe,
  input logic [NUM_CH-1:0]                  wrStrobe,
  input logic [NUM_CH-1:0]                  countEn,
  input logic [NUM_CH-1:0][CTRL_BITS-1:0]   ctrlState,
  input logic [NUM_CH-1:0][3:0][CNT_W-1:0]  cntArr
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(c * STRIDE + OFF_CTRL);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !countEn[c] |=> $stable(cntArr[c])); // R4

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      countEn[c] |=> cntArr[c][2] == $past(cntArr[c][2]) + 32'd1); // R5

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      countEn[c] && rdStrobe[c] |=> cntArr[c][1] == $past(cntArr[c][1]) + 32'd1); // R6

    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      countEn[c] && wrStrobe[c] |=> cntArr[c][0] == $past(cntArr[c][0]) + 32'd1); // R6

    AST_ACCESS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      countEn[c] && (rdStrobe[c] || wrStrobe[c]) |=> cntArr[c][3] == $past(cntArr[c][3]) + 32'd1); // R7

    AST_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      countEn[c] && !rdStrobe[c] && !wrStrobe[c] |=> $stable(cntArr[c][3])); // R7

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      psel && penable && pwrite && paddr == CTRL_ADDR && maskBits == '0 |=> $stable(ctrlState[c])); // R2
  end

endmodule

bind ddr_traffic_monitor ddrmon_checker #(
  .NUM_CH(NUM_CH), .STRIDE(STRIDE), .ADDR_W(ADDR_W)
) u_check (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .maskBits(pwdata[21:16]), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
  .countEn(dpCmd.countEn[NUM_CH-1:0]), .ctrlState(ctrlState), .cntArr(cntArr)
);

// File: tb/test_ddr_traffic_monitor.sv
module test_ddr_traffic_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, psel2 = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata2;
  logic [1:0]  rdS = '0, wrS = '0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ddr_traffic_monitor #(.NUM_CH(2), .STRIDE(20), .SHARED_CTRL(0), .ADDR_W(16)) i_ddr_traffic_monitor (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rdStrobe(rdS), .wrStrobe(wrS));

  ddr_traffic_monitor #(.NUM_CH(2), .STRIDE(16384), .SHARED_CTRL(1), .ADDR_W(16)) i_ddr_traffic_monitor_shared (
    .clk(clk), .rst_n(rst_n), .psel(psel2), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata2), .rdStrobe(rdS), .wrStrobe(wrS));

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic setSel(bit sh, logic v);
    if (sh) psel2 = v; else psel = v;
  endtask

  task automatic busWrite(bit sh, logic [15:0] a, logic [31:0] d);
    @(negedge clk); setSel(sh, 1'b1); pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; psel2 = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(bit sh, logic [15:0] a, output logic [31:0] d);
    @(negedge clk); setSel(sh, 1'b1); pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1;
    #1 d = sh ? prdata2 : prdata;
    @(negedge clk); psel = 1'b0; psel2 = 1'b0; penable = 1'b0;
  endtask

  // hold a read of one address for n clocks and return the change
  task automatic holdDelta(bit sh, logic [15:0] a, int n, output logic [31:0] d);
    logic [31:0] first, last;
    @(negedge clk); setSel(sh, 1'b1); pwrite = 1'b0; penable = 1'b1; paddr = a;
    #1 first = sh ? prdata2 : prdata;
    repeat (n) @(negedge clk);
    #1 last = sh ? prdata2 : prdata;
    psel = 1'b0; psel2 = 1'b0; penable = 1'b0;
    d = last - first;
  endtask

  // strobes on one channel: rdN read-only, wrN write-only, bothN both
  task automatic pulse(int ch, int rdN, int wrN, int bothN);
    for (int i = 0; i < rdN; i++)   begin @(negedge clk); rdS = 2'b01 << ch; wrS = 2'b00; end
    for (int i = 0; i < wrN; i++)   begin @(negedge clk); rdS = 2'b00; wrS = 2'b01 << ch; end
    for (int i = 0; i < bothN; i++) begin @(negedge clk); rdS = 2'b01 << ch; wrS = 2'b01 << ch; end
    @(negedge clk); rdS = 2'b00; wrS = 2'b00;
  endtask

  task automatic snap(bit sh, logic [15:0] base, output logic [31:0] v [4]);
    for (int k = 0; k < 4; k++) busRead(sh, base + 16'h20 + 16'(4 * k), v[k]);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [15:0] addrs [10] = '{16'h04, 16'h20, 16'h24, 16'h28, 16'h2C,
                                16'h18, 16'h34, 16'h38, 16'h3C, 16'h40};
    foreach (addrs[i]) begin
      busRead(0, addrs[i], d);
      check("R1", $sformatf("reset value @0x%0h", addrs[i]), d, 32'h0);
    end
    holdDelta(0, 16'h28, 6, d);
    check("R1", "cycle counter idle after reset", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    busWrite(0, 16'h04, 32'h0002_FFFF);
    busRead(0, 16'h04, d);
    check("R2", "only masked bit 1 written", d, 32'h2);
    busWrite(0, 16'h04, 32'h0034_0010);
    busRead(0, 16'h04, d);
    check("R3", "type field rewritten, enable kept", d, 32'h12);
    busWrite(0, 16'h04, 32'hFFC0_FFFF);
    busRead(0, 16'h04, d);
    check("R2", "mask on unstored bits 15:6", d, 32'h12);
    busWrite(0, 16'h04, 32'h0000_FFFF);
    busRead(0, 16'h04, d);
    check("R2", "empty mask keeps value", d, 32'h12);
    busWrite(0, 16'h04, 32'h003F_0000);
    busRead(0, 16'h04, d);
    check("R2", "full mask clears", d, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] a [4], b [4], d;
    busWrite(0, 16'h04, 32'h003F_0001);
    snap(0, 16'h00, a);
    pulse(0, 3, 2, 1);
    snap(0, 16'h00, b);
    for (int k = 0; k < 4; k++) check("R4", $sformatf("timer bit alone, counter %0d", k), b[k] - a[k], 32'h0);
    holdDelta(0, 16'h28, 10, d);
    check("R4", "cycles frozen with timer bit alone", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] a [4], b [4], d;
    busWrite(0, 16'h04, 32'h003F_0002);
    snap(0, 16'h00, a);
    pulse(0, 5, 3, 2);
    snap(0, 16'h00, b);
    check("R6", "write count delta", b[0] - a[0], 32'd5);
    check("R6", "read count delta", b[1] - a[1], 32'd7);
    check("R7", "access count, overlap counted once", b[3] - a[3], 32'd10);
    holdDelta(0, 16'h28, 25, d);
    check("R5", "cycle delta over 25 clocks", d, 32'd25);
  endtask

  task automatic t_hw();
    logic [31:0] a, b, d;
    busWrite(0, 16'h04, 32'h003F_0008);
    holdDelta(0, 16'h28, 12, d);
    check("R4", "hardware enable counts cycles", d, 32'd12);
    busRead(0, 16'h24, a);
    pulse(0, 2, 0, 0);
    busRead(0, 16'h24, b);
    check("R4", "hardware enable counts reads", b - a, 32'd2);
  endtask

  task automatic t_iso();
    logic [31:0] a0, a1, b0, b1, d;
    busWrite(0, 16'h04, 32'h003F_0002);
    busRead(0, 16'h38, a1); busRead(0, 16'h24, a0);
    pulse(1, 4, 0, 0);
    busRead(0, 16'h38, b1); busRead(0, 16'h24, b0);
    check("R4", "disabled ch1 ignores its reads", b1 - a1, 32'h0);
    check("R8", "ch1 strobes leave ch0 alone", b0 - a0, 32'h0);
    busWrite(0, 16'h18, 32'h003F_0002);
    busRead(0, 16'h18, d);
    check("R8", "ch1 control at stride offset", d, 32'h2);
    busRead(0, 16'h34, a1); busRead(0, 16'h20, a0);
    pulse(1, 0, 3, 0);
    busRead(0, 16'h34, b1); busRead(0, 16'h20, b0);
    check("R8", "ch1 write count at 0x34", b1 - a1, 32'd3);
    check("R8", "ch0 write count untouched", b0 - a0, 32'h0);
  endtask

  task automatic t_ignore();
    logic [31:0] a [4], b [4], c [4], d;
    busWrite(0, 16'h04, 32'h003F_0000);
    snap(0, 16'h00, a);
    snap(0, 16'h00, c);
    for (int k = 0; k < 4; k++) check("R9", $sformatf("read does not clear counter %0d", k), c[k], a[k]);
    check("R9", "counters hold real history", a[1], 32'd9);
    for (int k = 0; k < 4; k++) busWrite(0, 16'h20 + 16'(4 * k), 32'hFFFF_FFFF);
    snap(0, 16'h00, b);
    for (int k = 0; k < 4; k++) check("R9", $sformatf("counter write ignored %0d", k), b[k], a[k]);
    busRead(0, 16'h00, d); check("R10", "unmapped 0x00", d, 32'h0);
    busRead(0, 16'h08, d); check("R10", "unmapped 0x08", d, 32'h0);
    busRead(0, 16'h1C, d); check("R10", "unmapped 0x1C", d, 32'h0);
    busRead(0, 16'h44, d); check("R10", "unmapped 0x44", d, 32'h0);
    busWrite(0, 16'h08, 32'h003F_003F);
    busRead(0, 16'h04, d); check("R10", "unmapped write leaves ch0 control", d, 32'h0);
  endtask

  task automatic t_shared();
    logic [31:0] d, a, b;
    busWrite(1, 16'h4004, 32'h003F_0002);
    busRead(1, 16'h4004, d);
    check("R11", "non-zero control offset reads zero", d, 32'h0);
    holdDelta(1, 16'h4028, 8, d);
    check("R11", "ch1 control write had no effect", d, 32'h0);
    busWrite(1, 16'h0004, 32'h003F_0002);
    busRead(1, 16'h0004, d);
    check("R11", "ch0 control readback", d, 32'h2);
    holdDelta(1, 16'h4028, 8, d);
    check("R11", "ch1 follows ch0 enable", d, 32'd8);
    busRead(1, 16'h4024, a);
    pulse(1, 3, 0, 0);
    busRead(1, 16'h4024, b);
    check("R11", "ch1 reads counted under ch0 control", b - a, 32'd3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask();
    t_gate();
    t_count();
    t_hw();
    t_iso();
    t_ignore();
    t_shared();
    finished = 1;
    summary();
  end

endmodule